// File: doc/BRIEF.md
# Shared Weight Memory Overlap Scheduler

This block sits between a forward (inference) engine, a plasticity (weight update) engine and one dual-port weight memory that both engines share. The memory holds one weight region per layer. At any time one layer is assigned to the forward role and a different layer to the update role. When both engines report that their work for the timestep is finished, the roles rotate, so that the layer that has just been read for inference is updated next. Each engine gives addresses local to its current layer. The block adds the layer index as the upper address bits. Only one copy of the weights exists.

Port A serves forward reads only. Port B serves the plasticity engine's reads and the commits of its writes. Writes are posted into a small write buffer and drain onto port B whenever the plasticity engine is not reading. If the plasticity engine keeps port B busy, writes stay buffered, even across a role swap. When any read targets an address that still has a buffered write, the write goes first. The read is held (ready low, stall high) and the buffer is forced to drain until no buffered write matches. A read therefore always sees every write that was accepted before it.

All request channels use valid/ready. A request transfers in a cycle where valid and ready are both high. Once valid is raised, it and the address must stay unchanged until that transfer. Read data returns with a valid flag exactly one cycle after the transfer and cannot be back-pressured. The done inputs, layer outputs and stall flags are plain control pins.

Top module: `wos_sched`

## Requirements
- R1: After reset the forward role is layer 1 and the update role is layer 0. `step_end`, `fwd_stall` and `pl_stall` are low, `pl_wr_ready` is high, and every weight word reads as zero.
- R2: A forward read transferred in cycle t gives `fwd_rsp_valid` high in cycle t+1, with the word at physical address {fwd_layer, fwd_rd_addr}. The layer index forms the upper address bits and the local address the lower LAYER_AW bits.
- R3: A plasticity read transferred in cycle t gives `pl_rsp_valid` high in cycle t+1, with the word at {pl_layer, pl_rd_addr}.
- R4: Plasticity writes are accepted into a write buffer of WB_DEPTH entries at address {pl_layer, pl_wr_addr}. `pl_wr_ready` is low exactly when the buffer is full.
- R5: Any read returns the data of the last write accepted in an earlier cycle to the same physical address, or zero if there was none.
- R6: A forward read whose address matches a buffered write is stalled: `fwd_rd_ready` is low and `fwd_stall` is high. The buffer drains on port B, taking port B even from a pending plasticity read, until the match is gone.
- R7: A plasticity read whose address matches a buffered write is stalled: `pl_rd_ready` is low and `pl_stall` is high. The buffer drains until the match is gone.
- R8: When there is no hazard, a plasticity read takes port B ahead of the buffer drain, and the buffer drains in cycles with no plasticity read.
- R9: Each done input is remembered until both have been seen; they may arrive in the same cycle or in different cycles. In the cycle after both have been seen, `step_end` is high for one cycle and the roles rotate: the forward layer advances by one modulo NUM_LAYERS, and the update layer is the one before it.
- R10: A done from only one engine never rotates the roles.
- R11: A forward read without a hazard is always ready, whatever the plasticity engine is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fwd_rd_valid | input | 1 | Forward read request valid |
| fwd_rd_ready | output | 1 | Forward read request accepted |
| fwd_rd_addr | input | LAYER_AW | Forward read address within the layer |
| fwd_rsp_valid | output | 1 | Forward read data valid |
| fwd_rsp_data | output | DATA_W | Forward read data |
| pl_rd_valid | input | 1 | Plasticity read request valid |
| pl_rd_ready | output | 1 | Plasticity read request accepted |
| pl_rd_addr | input | LAYER_AW | Plasticity read address within the layer |
| pl_rsp_valid | output | 1 | Plasticity read data valid |
| pl_rsp_data | output | DATA_W | Plasticity read data |
| pl_wr_valid | input | 1 | Plasticity write valid |
| pl_wr_ready | output | 1 | Plasticity write accepted |
| pl_wr_addr | input | LAYER_AW | Plasticity write address within the layer |
| pl_wr_data | input | DATA_W | Plasticity write data |
| fwd_done | input | 1 | Forward engine finished its timestep |
| pl_done | input | 1 | Plasticity engine finished its timestep |
| fwd_layer | output | LAYER_IW | Layer currently in the forward role |
| pl_layer | output | LAYER_IW | Layer currently in the update role |
| fwd_stall | output | 1 | Forward read held by a write hazard |
| pl_stall | output | 1 | Plasticity read held by a write hazard or a forced drain |
| step_end | output | 1 | One-cycle pulse as the roles rotate |

## Verification
The hardest case to reach is a forward read that meets a write still waiting in the buffer. Writes only wait while the plasticity engine holds port B with reads. Within a timestep the two roles never share a layer, so the collision can only happen after a role swap. The stimulus keeps plasticity reads asserted without a break and posts writes into the update layer, so they stay buffered. It then raises both done inputs and, once the roles have swapped, issues forward reads to the written addresses. The bench checks that these reads stall, that the forced drain takes port B from the waiting plasticity read, and that the data returned is the new value.

// File: rtl/wos_pkg.sv
package wos_pkg;

  // Use of memory port B in a given cycle
  typedef enum logic [1:0] {
    PB_IDLE    = 2'd0,
    PB_PL_READ = 2'd1,
    PB_DRAIN   = 2'd2
  } portb_use_e;

endpackage

// File: rtl/wos_wmem.sv
module wos_wmem #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_re,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_rdata,
  input  logic          b_re,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Weights start at zero; port B is the only writer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (b_we) begin
      mem[b_addr] <= b_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (a_re) a_rdata <= mem[a_addr];
    if (b_re) b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/wos_wbuf.sv
module wos_wbuf #(
  parameter int AW    = 5,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          full,
  output logic          empty,
  input  logic [AW-1:0] look_a,
  input  logic [AW-1:0] look_b,
  output logic          hit_a,
  output logic          hit_b
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;

  logic [AW-1:0] ent_addr [DEPTH];
  logic [DW-1:0] ent_data [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic [DEPTH-1:0] live, match_a, match_b;

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign head_addr = ent_addr[rd_ptr];
  assign head_data = ent_data[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        ent_addr[wr_ptr] <= push_addr;
        ent_data[wr_ptr] <= push_data;
        wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  // Per-entry occupancy and address comparison against both lookups
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [PW-1:0] age;
    always_comb begin
      age        = (PW'(g) >= rd_ptr) ? PW'(g) - rd_ptr : PW'(g + DEPTH) - rd_ptr;
      live[g]    = ({1'b0, age} < count);
      match_a[g] = live[g] && (ent_addr[g] == look_a);
      match_b[g] = live[g] && (ent_addr[g] == look_b);
    end
  end

  assign hit_a = |match_a;
  assign hit_b = |match_b;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R6

endmodule

// File: rtl/wos_roles.sv
module wos_roles #(
  parameter int NUM_LAYERS = 2,
  parameter int LW         = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwd_done,
  input  logic          pl_done,
  output logic [LW-1:0] fwd_layer,
  output logic [LW-1:0] pl_layer,
  output logic          step_end
);
  localparam logic [LW-1:0] LAST = LW'(NUM_LAYERS - 1);

  logic [LW-1:0] cur;
  logic fwd_seen, pl_seen, both;

  assign both      = (fwd_seen | fwd_done) & (pl_seen | pl_done);
  assign fwd_layer = cur;
  assign pl_layer  = (cur == '0) ? LAST : cur - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur      <= LW'(1);
      fwd_seen <= 1'b0;
      pl_seen  <= 1'b0;
      step_end <= 1'b0;
    end else begin
      step_end <= both;
      if (both) begin
        cur      <= (cur == LAST) ? '0 : cur + 1'b1;
        fwd_seen <= 1'b0;
        pl_seen  <= 1'b0;
      end else begin
        fwd_seen <= fwd_seen | fwd_done;
        pl_seen  <= pl_seen | pl_done;
      end
    end
  end

  AST_ROLES_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_layer != pl_layer); // R9
  AST_SWAP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    step_end |-> fwd_layer != $past(fwd_layer)); // R9
  AST_ROLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !both |=> $stable(fwd_layer)); // R10

endmodule

// File: rtl/wos_portb_arb.sv
module wos_portb_arb
  import wos_pkg::*;
(
  input  logic       fwd_valid,
  input  logic       fwd_hit,
  input  logic       pl_valid,
  input  logic       pl_hit,
  input  logic       wb_empty,
  output logic       fwd_ready,
  output logic       fwd_stall,
  output logic       pl_ready,
  output logic       pl_stall,
  output logic       drain,
  output portb_use_e b_use
);
  logic forced;

  always_comb begin
    forced    = (fwd_valid & fwd_hit) | (pl_valid & pl_hit);
    // Writes go first on a hazard; otherwise a waiting read owns port B
    drain     = !wb_empty && (forced || !pl_valid);
    fwd_ready = !fwd_hit;
    fwd_stall = fwd_valid & fwd_hit;
    pl_ready  = !pl_hit && !(fwd_valid && fwd_hit);
    pl_stall  = pl_valid & !pl_ready;
    if (drain)                    b_use = PB_DRAIN;
    else if (pl_valid && pl_ready) b_use = PB_PL_READ;
    else                          b_use = PB_IDLE;
  end

endmodule

// File: rtl/wos_sched.sv
module wos_sched
  import wos_pkg::*;
#(
  parameter int NUM_LAYERS = 2,
  parameter int LAYER_AW   = 4,
  parameter int DATA_W     = 16,
  parameter int WB_DEPTH   = 4,
  localparam int LAYER_IW  = $clog2(NUM_LAYERS),
  localparam int PAW       = LAYER_IW + LAYER_AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fwd_rd_valid,
  output logic                fwd_rd_ready,
  input  logic [LAYER_AW-1:0] fwd_rd_addr,
  output logic                fwd_rsp_valid,
  output logic [DATA_W-1:0]   fwd_rsp_data,
  input  logic                pl_rd_valid,
  output logic                pl_rd_ready,
  input  logic [LAYER_AW-1:0] pl_rd_addr,
  output logic                pl_rsp_valid,
  output logic [DATA_W-1:0]   pl_rsp_data,
  input  logic                pl_wr_valid,
  output logic                pl_wr_ready,
  input  logic [LAYER_AW-1:0] pl_wr_addr,
  input  logic [DATA_W-1:0]   pl_wr_data,
  input  logic                fwd_done,
  input  logic                pl_done,
  output logic [LAYER_IW-1:0] fwd_layer,
  output logic [LAYER_IW-1:0] pl_layer,
  output logic                fwd_stall,
  output logic                pl_stall,
  output logic                step_end
);
  logic [PAW-1:0] fwd_phys, plr_phys, plw_phys, head_addr, b_addr;
  logic [DATA_W-1:0] head_data;
  logic wb_full, wb_empty, fwd_hit, pl_hit, drain, wr_push, fwd_take, pl_take;
  portb_use_e b_use;

  wos_roles #(.NUM_LAYERS(NUM_LAYERS), .LW(LAYER_IW)) u_roles (
    .clk(clk), .rst_n(rst_n), .fwd_done(fwd_done), .pl_done(pl_done),
    .fwd_layer(fwd_layer), .pl_layer(pl_layer), .step_end(step_end)
  );

  assign fwd_phys = {fwd_layer, fwd_rd_addr};
  assign plr_phys = {pl_layer, pl_rd_addr};
  assign plw_phys = {pl_layer, pl_wr_addr};

  assign pl_wr_ready = !wb_full;
  assign wr_push     = pl_wr_valid & pl_wr_ready;

  wos_wbuf #(.AW(PAW), .DW(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk(clk), .rst_n(rst_n),
    .push(wr_push), .push_addr(plw_phys), .push_data(pl_wr_data),
    .pop(drain), .head_addr(head_addr), .head_data(head_data),
    .full(wb_full), .empty(wb_empty),
    .look_a(fwd_phys), .look_b(plr_phys), .hit_a(fwd_hit), .hit_b(pl_hit)
  );

  wos_portb_arb u_arb (
    .fwd_valid(fwd_rd_valid), .fwd_hit(fwd_hit),
    .pl_valid(pl_rd_valid), .pl_hit(pl_hit), .wb_empty(wb_empty),
    .fwd_ready(fwd_rd_ready), .fwd_stall(fwd_stall),
    .pl_ready(pl_rd_ready), .pl_stall(pl_stall),
    .drain(drain), .b_use(b_use)
  );

  assign fwd_take = fwd_rd_valid & fwd_rd_ready;
  assign pl_take  = (b_use == PB_PL_READ);
  assign b_addr   = (b_use == PB_DRAIN) ? head_addr : plr_phys;

  wos_wmem #(.AW(PAW), .DW(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .a_re(fwd_take), .a_addr(fwd_phys), .a_rdata(fwd_rsp_data),
    .b_re(pl_take), .b_we(b_use == PB_DRAIN), .b_addr(b_addr),
    .b_wdata(head_data), .b_rdata(pl_rsp_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_rsp_valid <= 1'b0;
      pl_rsp_valid  <= 1'b0;
    end else begin
      fwd_rsp_valid <= fwd_take;
      pl_rsp_valid  <= pl_take;
    end
  end

  AST_FWD_HAZARD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_rd_valid && fwd_hit) |-> (!fwd_rd_ready && fwd_stall)); // R6
  AST_FWD_STALL_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_stall |-> (drain && !pl_take)); // R6
  AST_PL_HAZARD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_rd_valid && pl_hit) |-> (!pl_rd_ready && drain)); // R7
  AST_PORTB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    drain |-> !(pl_rd_valid && pl_rd_ready)); // R8
  AST_FWD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_rd_valid && !fwd_hit) |-> fwd_rd_ready); // R11
  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_rd_valid && fwd_rd_ready) |=> fwd_rsp_valid); // R2

endmodule

// File: tb/tb_wos_sched.sv
`timescale 1ns/1ps
module tb_wos_sched;
  localparam int NL = 2;
  localparam int LAW = 4;
  localparam int DW = 16;
  localparam int WBD = 4;
  localparam int LIW = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fwd_rd_valid = 0, pl_rd_valid = 0, pl_wr_valid = 0, fwd_done = 0, pl_done = 0;
  logic [LAW-1:0] fwd_rd_addr = '0, pl_rd_addr = '0, pl_wr_addr = '0;
  logic [DW-1:0] pl_wr_data = '0;
  logic fwd_rd_ready, fwd_rsp_valid, pl_rd_ready, pl_rsp_valid, pl_wr_ready;
  logic fwd_stall, pl_stall, step_end;
  logic [DW-1:0] fwd_rsp_data, pl_rsp_data;
  logic [LIW-1:0] fwd_layer, pl_layer;

  always #2 clk = ~clk;

  wos_sched dut (
    .clk(clk), .rst_n(rst_n),
    .fwd_rd_valid(fwd_rd_valid), .fwd_rd_ready(fwd_rd_ready), .fwd_rd_addr(fwd_rd_addr),
    .fwd_rsp_valid(fwd_rsp_valid), .fwd_rsp_data(fwd_rsp_data),
    .pl_rd_valid(pl_rd_valid), .pl_rd_ready(pl_rd_ready), .pl_rd_addr(pl_rd_addr),
    .pl_rsp_valid(pl_rsp_valid), .pl_rsp_data(pl_rsp_data),
    .pl_wr_valid(pl_wr_valid), .pl_wr_ready(pl_wr_ready), .pl_wr_addr(pl_wr_addr),
    .pl_wr_data(pl_wr_data), .fwd_done(fwd_done), .pl_done(pl_done),
    .fwd_layer(fwd_layer), .pl_layer(pl_layer), .fwd_stall(fwd_stall),
    .pl_stall(pl_stall), .step_end(step_end)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: shadow weights and role tracking
  logic [DW-1:0] shadow [NL << LAW];
  logic [DW-1:0] fq[$], pq[$];
  int m_fwd = 1, m_pl = 0;
  bit fs = 0, ps = 0, swap_pend = 0;

  // Scoreboard: collects expectations on transfers and compares responses
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (NL << LAW); i++) shadow[i] = '0;
      fq.delete(); pq.delete();
      m_fwd = 1; m_pl = 0; fs = 0; ps = 0; swap_pend = 0;
    end else begin
      bit se_exp;
      se_exp = swap_pend;
      if (swap_pend) begin
        m_fwd = (m_fwd == NL - 1) ? 0 : m_fwd + 1;
        m_pl = (m_fwd == 0) ? NL - 1 : m_fwd - 1;
        swap_pend = 0;
      end
      chk(step_end == se_exp, "R9 step_end", int'(step_end), int'(se_exp));
      chk(int'(fwd_layer) == m_fwd && int'(pl_layer) == m_pl, "R9/R10 layers",
          int'(fwd_layer), m_fwd);
      if (fwd_rsp_valid) begin
        if (fq.size() == 0) chk(0, "R2 unexpected fwd rsp", 1, 0);
        else begin
          logic [DW-1:0] e;
          e = fq.pop_front();
          chk(fwd_rsp_data == e, "R2/R5 fwd data", int'(fwd_rsp_data), int'(e));
        end
      end
      if (pl_rsp_valid) begin
        if (pq.size() == 0) chk(0, "R3 unexpected pl rsp", 1, 0);
        else begin
          logic [DW-1:0] e;
          e = pq.pop_front();
          chk(pl_rsp_data == e, "R3/R5 pl data", int'(pl_rsp_data), int'(e));
        end
      end
      if (fwd_rd_valid && fwd_rd_ready) fq.push_back(shadow[m_fwd * (1 << LAW) + int'(fwd_rd_addr)]);
      if (pl_rd_valid && pl_rd_ready) pq.push_back(shadow[m_pl * (1 << LAW) + int'(pl_rd_addr)]);
      if (pl_wr_valid && pl_wr_ready) shadow[m_pl * (1 << LAW) + int'(pl_wr_addr)] = pl_wr_data;
      if ((fs || fwd_done) && (ps || pl_done)) begin
        swap_pend = 1; fs = 0; ps = 0;
      end else begin
        fs = fs | fwd_done; ps = ps | pl_done;
      end
    end
  end

  // Drivers: inputs change 1 ns after the rising edge
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic fwd_read(input int a);
    bit ok = 0;
    fwd_rd_valid = 1; fwd_rd_addr = LAW'(a);
    while (!ok) begin @(negedge clk); ok = fwd_rd_ready; tick(); end
    fwd_rd_valid = 0;
  endtask

  task automatic pl_read(input int a);
    bit ok = 0;
    pl_rd_valid = 1; pl_rd_addr = LAW'(a);
    while (!ok) begin @(negedge clk); ok = pl_rd_ready; tick(); end
    pl_rd_valid = 0;
  endtask

  task automatic pl_write(input int a, input int d);
    bit ok = 0;
    pl_wr_valid = 1; pl_wr_addr = LAW'(a); pl_wr_data = DW'(d);
    while (!ok) begin @(negedge clk); ok = pl_wr_ready; tick(); end
    pl_wr_valid = 0;
  endtask

  task automatic pulse(input bit f, input bit p);
    fwd_done = f; pl_done = p; tick();
    fwd_done = 0; pl_done = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(fwd_layer == 1, "R1 fwd_layer", int'(fwd_layer), 1);
    chk(pl_layer == 0, "R1 pl_layer", int'(pl_layer), 0);
    chk(!step_end && !fwd_stall && !pl_stall, "R1 flags", int'(step_end), 0);
    chk(pl_wr_ready == 1, "R1 pl_wr_ready", int'(pl_wr_ready), 1);
    tick();
    // R1/R2 zero weights seen by forward reads of layer 1
    for (int i = 0; i < 16; i++) fwd_read(i);
    // R3/R5 writes to layer 0 drain when port B idle, then read back
    for (int i = 0; i < 4; i++) pl_write(i, 16'h100 + i);
    repeat (3) tick();
    for (int i = 0; i < 4; i++) pl_read(i);
    // R4/R8 buffer fills while plasticity reads hold port B
    pl_rd_valid = 1; pl_rd_addr = 15;
    for (int i = 4; i < 8; i++) pl_write(i, 16'h200 + i);
    @(negedge clk);
    chk(pl_wr_ready == 0, "R4 buffer full", int'(pl_wr_ready), 0);
    chk(pl_rd_ready == 1, "R8 read keeps port B", int'(pl_rd_ready), 1);
    tick();
    pl_rd_valid = 0;
    repeat (6) tick();
    @(negedge clk);
    chk(pl_wr_ready == 1, "R8 drain when idle", int'(pl_wr_ready), 1);
    tick();
    for (int i = 4; i < 8; i++) pl_read(i);
    // R10 single done does not rotate; R9 second done does
    pulse(1, 0);
    repeat (3) tick();
    @(negedge clk);
    chk(fwd_layer == 1 && !step_end, "R10 one done only", int'(fwd_layer), 1);
    tick();
    pulse(0, 1);
    @(negedge clk);
    chk(step_end == 1, "R9 step_end pulse", int'(step_end), 1);
    chk(fwd_layer == 0 && pl_layer == 1, "R9 roles rotated", int'(fwd_layer), 0);
    tick();
    // R2 forward now sees updated layer 0
    for (int i = 0; i < 8; i++) fwd_read(i);
    // Rotate back: both dones in one cycle
    pulse(1, 1);
    @(negedge clk);
    chk(fwd_layer == 1 && pl_layer == 0, "R9 same-cycle dones", int'(fwd_layer), 1);
    tick();
    // R6 hazard across a swap: writes held back by continuous reads
    pl_rd_valid = 1; pl_rd_addr = 15;
    pl_write(2, 16'hA0A0);
    pl_write(3, 16'hB0B0);
    pulse(1, 1);
    tick();
    @(negedge clk);
    chk(fwd_layer == 0, "R9 swap before hazard", int'(fwd_layer), 0);
    tick();
    fwd_rd_valid = 1; fwd_rd_addr = 2;
    @(negedge clk);
    chk(fwd_stall == 1 && fwd_rd_ready == 0, "R6 fwd stall", int'(fwd_stall), 1);
    chk(pl_rd_ready == 0 && pl_stall == 1, "R6 drain takes port B", int'(pl_rd_ready), 0);
    tick();
    fwd_read(2);
    fwd_read(3);
    // R11 forward reads run freely alongside plasticity reads
    for (int i = 8; i < 12; i++) begin
      fwd_rd_valid = 1; fwd_rd_addr = LAW'(i);
      @(negedge clk);
      chk(fwd_rd_ready == 1, "R11 fwd ready", int'(fwd_rd_ready), 1);
      tick();
    end
    fwd_rd_valid = 0;
    // R7 plasticity read of its own buffered write (layer 1)
    pl_write(9, 16'hC3C3);
    pl_rd_addr = 9;
    @(negedge clk);
    chk(pl_stall == 1 && pl_rd_ready == 0, "R7 pl stall", int'(pl_stall), 1);
    tick();
    repeat (3) tick();
    pl_rd_valid = 0;
    // R5 read and write of one address in the same cycle: read sees old
    pl_rd_valid = 1; pl_rd_addr = 5; pl_wr_valid = 1; pl_wr_addr = 5; pl_wr_data = 16'h5555;
    tick();
    pl_rd_valid = 0; pl_wr_valid = 0;
    repeat (3) tick();
    pl_read(5);
    repeat (4) tick();
    @(negedge clk);
    chk(fq.size() == 0 && pq.size() == 0, "R5 all responses seen", fq.size() + pq.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule